// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block is the host-side master for a three-wire serial EEPROM organised as 16-bit words. A host presents one of four operations (read a word, write a word, enable writes, disable writes) together with an 8-bit word address, and write data when it writes. The block builds the serial command frame, sends it MSB first on the data output while it toggles the serial clock under chip select, and for a read it clocks 16 data bits back in from the device.

A word write is a complete sequence with no host help. The block enables writes, erases the addressed word and waits for the device to report ready, programs the word and waits again, then disables writes. Between any two frames, and after every ready wait, chip select stays low for one full bit period. A ready wait keeps chip select high with the clock idle and watches the device's data line until it goes high. A bounded counter guards each wait. If it runs out, the block flags an error, skips the rest of the program steps and still sends the disable frame. The bit timing comes from a parameterised divider. Each serial bit takes three phases of `PHASE_CYC` clock cycles each.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, err_o, cs_o and sk_o are all 0.
- R2: Every command frame begins with an 11-bit header sent MSB first: a 1 start bit, a 2-bit device opcode, then the 8-bit address. The device opcodes are read = 10, write = 01, erase = 11, and 00 for the enable/disable family. op_i encodes the host operation as 0 = read, 1 = write, 2 = enable writes, 3 = disable writes.
- R3: Each sent bit takes three phases of PHASE_CYC cycles with cs_o high: di_o is set while sk_o is low, then sk_o goes high, then sk_o goes low. di_o does not change while sk_o is high, and sk_o is never high while cs_o is low.
- R4: A read sends the 11-bit header with opcode 10. It then gives 16 more clock pulses with di_o at 0, samples do_i while sk_o is high, assembles the bits MSB first and presents the word on rdata_o when done_o pulses.
- R5: The enable-writes frame is 1, 0, 0 followed by eight 1 bits (opcode 00, address all ones). The disable-writes frame is a 1 followed by ten 0 bits.
- R6: A write runs these steps in order: enable frame, erase frame (opcode 11 with the address), ready wait, 27-bit program frame (opcode 01, address, then the 16 data bits MSB first), ready wait, disable frame.
- R7: After every frame and every ready wait, cs_o is low for at least one bit period (3 x PHASE_CYC cycles) before cs_o rises again.
- R8: A ready wait raises cs_o with no sk_o pulse and ends once do_i is sampled as 1.
- R9: If do_i stays 0 for POLL_MAX phases of a ready wait, err_o is set, the remaining program steps are skipped, the disable frame is still sent, and then done_o pulses. err_o holds until the next accepted request clears it.
- R10: A request is accepted only while busy_o is 0. busy_o is 1 from the cycle after acceptance until done_o. done_o is a one-cycle pulse in the cycle busy_o falls. A request made while busy_o is 1 produces no frame and no change to the operation in progress.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Operation request, sampled while idle |
| op_i | input | 2 | Host operation: 0 read, 1 write, 2 enable writes, 3 disable writes |
| addr_i | input | 8 | Word address |
| wdata_i | input | 16 | Word to program on a write |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Ready-wait timeout occurred in the last operation |
| rdata_o | output | 16 | Word returned by the last read |
| cs_o | output | 1 | Device chip select, active high |
| sk_o | output | 1 | Device serial clock |
| di_o | output | 1 | Serial data to the device |
| do_i | input | 1 | Serial data and ready indication from the device |

## Verification
Some properties must hold on every cycle, and the embedded assertions check these. The serial clock is never high without chip select, and the data output does not move while the clock is high. Chip select is low whenever the block is idle. The done pulse is one cycle wide and falls together with busy. The latched operation cannot change mid-sequence, and the ready-wait counter stays inside its bound. The bench scenarios are needed for the rest: the bit content and order of each frame, the complete erase-program-disable sequence, read data assembly, the minimum deselect gap, and the timeout path that jumps ahead to the disable frame. A pin-level device model supplies the data and the delayed ready for these.

// File: rtl/uwire_pkg.sv
`timescale 1ns/1ps
package uwire_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WEN   = 2'd2,
    OP_WDS   = 2'd3
  } host_op_e;

  typedef enum logic [1:0] {
    K_FRAME = 2'd0,
    K_DESEL = 2'd1,
    K_POLL  = 2'd2
  } eng_kind_e;

  localparam logic [1:0] DEV_RD   = 2'b10;
  localparam logic [1:0] DEV_WR   = 2'b01;
  localparam logic [1:0] DEV_ER   = 2'b11;
  localparam logic [1:0] DEV_MISC = 2'b00;
endpackage

// File: rtl/uwire_tick.sv
`timescale 1ns/1ps
module uwire_tick #(
  parameter int PHASE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (cnt_q == CW'(PHASE_CYC-1))  cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q == CW'(PHASE_CYC-1));
endmodule

// File: rtl/uwire_engine.sv
`timescale 1ns/1ps
module uwire_engine
  import uwire_pkg::*;
#(
  parameter int FRAME_W  = 27,
  parameter int DATA_W   = 16,
  parameter int POLL_MAX = 64,
  localparam int CNT_W   = $clog2(FRAME_W+1),
  localparam int TO_W    = $clog2(POLL_MAX+1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  eng_kind_e          kind_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic               rx_i,
  input  logic               do_i,
  output logic               done_o,
  output logic               timeout_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               cs_o,
  output logic               sk_o,
  output logic               di_o
);
  typedef enum logic [2:0] {E_IDLE, E_TX, E_RX, E_DESEL, E_POLL} eng_st_e;

  eng_st_e            st_q;
  logic [1:0]         ph_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   len_q;
  logic [FRAME_W-1:0] sh_q;
  logic [DATA_W-1:0]  rx_sh_q;
  logic               rx_q;
  logic [TO_W-1:0]    to_cnt_q;
  logic               done_q;
  logic               tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= E_IDLE;
      ph_q     <= '0;
      cnt_q    <= '0;
      len_q    <= '0;
      sh_q     <= '0;
      rx_sh_q  <= '0;
      rx_q     <= 1'b0;
      to_cnt_q <= '0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (st_q)
        E_IDLE: if (start_i) begin
          ph_q     <= '0;
          cnt_q    <= '0;
          to_cnt_q <= '0;
          sh_q     <= frame_i;
          len_q    <= len_i;
          rx_q     <= rx_i;
          unique case (kind_i)
            K_FRAME: st_q <= E_TX;
            K_DESEL: st_q <= E_DESEL;
            K_POLL:  st_q <= E_POLL;
            default: st_q <= E_DESEL;
          endcase
        end
        E_TX: if (tick_i) begin
          if (ph_q == 2'd2) begin
            ph_q <= '0;
            sh_q <= sh_q << 1;
            if (cnt_q == len_q - CNT_W'(1)) begin
              cnt_q <= '0;
              if (rx_q) st_q <= E_RX;
              else begin
                st_q   <= E_IDLE;
                done_q <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        E_RX: if (tick_i) begin
          if (ph_q == 2'd0) begin
            rx_sh_q <= {rx_sh_q[DATA_W-2:0], do_i};  // sample at end of clock-high phase
            ph_q    <= 2'd1;
          end else begin
            ph_q <= '0;
            if (cnt_q == CNT_W'(DATA_W-1)) begin
              st_q   <= E_IDLE;
              done_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        E_DESEL: if (tick_i) begin
          if (ph_q == 2'd2) begin
            st_q   <= E_IDLE;
            done_q <= 1'b1;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        E_POLL: if (tick_i) begin
          if (do_i) begin
            st_q   <= E_IDLE;
            done_q <= 1'b1;
          end else if (to_cnt_q == TO_W'(POLL_MAX-1)) begin
            st_q   <= E_IDLE;
            done_q <= 1'b1;
            tmo_q  <= 1'b1;
          end else begin
            to_cnt_q <= to_cnt_q + 1'b1;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign cs_o      = (st_q == E_TX) || (st_q == E_RX) || (st_q == E_POLL);
  assign sk_o      = ((st_q == E_TX) && (ph_q == 2'd1)) || ((st_q == E_RX) && (ph_q == 2'd0));
  assign di_o      = (st_q == E_TX) && sh_q[FRAME_W-1];
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
  assign rdata_o   = rx_sh_q;

  a_r3_di_stable_clock_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o && $past(sk_o)) |-> $stable(di_o));
  a_r4_rx_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_RX) |-> (cnt_q < CNT_W'(DATA_W)));
  a_r9_wait_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_cnt_q < TO_W'(POLL_MAX));
  a_r9_timeout_from_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |-> ($past(st_q) == E_POLL) && done_q);
endmodule

// File: rtl/uwire_seq.sv
`timescale 1ns/1ps
module uwire_seq
  import uwire_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  localparam int CMD_W   = 3 + ADDR_W,
  localparam int FRAME_W = CMD_W + DATA_W,
  localparam int LEN_W   = $clog2(FRAME_W+1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [1:0]         op_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               eng_done_i,
  input  logic               eng_tmo_i,
  input  logic [DATA_W-1:0]  eng_rdata_i,
  output logic               start_o,
  output eng_kind_e          kind_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               rx_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [DATA_W-1:0]  rdata_o
);
  typedef enum logic [3:0] {
    S_IDLE, S_EN, S_EN_D, S_ER, S_ER_D, S_ER_P, S_ER_PD,
    S_WR, S_WR_D, S_WR_P, S_WR_PD, S_DI, S_DI_D, S_RD, S_RD_D
  } seq_st_e;

  seq_st_e           st_q, nxt_st;
  host_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              go_q, done_q, err_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    unique case (st_q)
      S_EN:    nxt_st = S_EN_D;
      S_EN_D:  nxt_st = (op_q == OP_WRITE) ? S_ER : S_IDLE;
      S_ER:    nxt_st = S_ER_D;
      S_ER_D:  nxt_st = S_ER_P;
      S_ER_P:  nxt_st = S_ER_PD;
      S_ER_PD: nxt_st = err_q ? S_DI : S_WR;  // timeout still closes with disable
      S_WR:    nxt_st = S_WR_D;
      S_WR_D:  nxt_st = S_WR_P;
      S_WR_P:  nxt_st = S_WR_PD;
      S_WR_PD: nxt_st = S_DI;
      S_DI:    nxt_st = S_DI_D;
      S_RD:    nxt_st = S_RD_D;
      default: nxt_st = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      data_q  <= '0;
      go_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      if (st_q == S_IDLE) begin
        if (req_i) begin
          op_q   <= host_op_e'(op_i);
          addr_q <= addr_i;
          data_q <= wdata_i;
          err_q  <= 1'b0;
          go_q   <= 1'b1;
          unique case (host_op_e'(op_i))
            OP_READ: st_q <= S_RD;
            OP_WDS:  st_q <= S_DI;
            default: st_q <= S_EN;
          endcase
        end
      end else if (eng_done_i) begin
        if (st_q == S_RD) rdata_q <= eng_rdata_i;
        if (((st_q == S_ER_P) || (st_q == S_WR_P)) && eng_tmo_i) err_q <= 1'b1;
        st_q <= nxt_st;
        if (nxt_st == S_IDLE) done_q <= 1'b1;
        else                  go_q   <= 1'b1;
      end
    end
  end

  always_comb begin
    logic [1:0]        opc;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    opc = DEV_MISC;
    a   = '0;
    d   = '0;
    unique case (st_q)
      S_EN:    a = '1;
      S_ER:    begin opc = DEV_ER; a = addr_q; end
      S_WR:    begin opc = DEV_WR; a = addr_q; d = data_q; end
      S_RD:    begin opc = DEV_RD; a = addr_q; end
      default: ;
    endcase
    frame_o = {1'b1, opc, a, d};
  end

  always_comb begin
    unique case (st_q)
      S_EN, S_ER, S_WR, S_DI, S_RD: kind_o = K_FRAME;
      S_ER_P, S_WR_P:               kind_o = K_POLL;
      default:                      kind_o = K_DESEL;
    endcase
  end

  assign len_o   = (st_q == S_WR) ? LEN_W'(FRAME_W) : LEN_W'(CMD_W);
  assign rx_o    = (st_q == S_RD);
  assign start_o = go_q;
  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  a_r10_held_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q != S_IDLE) && $past(st_q != S_IDLE)) |-> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));
  a_r9_err_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (op_q == OP_WRITE));
  a_r6_program_after_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_WR) && $past(st_q != S_WR)) |-> ($past(st_q) == S_ER_PD));
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
`timescale 1ns/1ps
module uwire_eeprom_ctrl
  import uwire_pkg::*;
#(
  parameter int PHASE_CYC = 4,
  parameter int POLL_MAX  = 64,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i
);
  localparam int CMD_W   = 3 + ADDR_W;
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int LEN_W   = $clog2(FRAME_W+1);

  logic               tick, start, rx, eng_done, eng_tmo;
  eng_kind_e          kind;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic [DATA_W-1:0]  eng_rdata;

  uwire_tick #(.PHASE_CYC(PHASE_CYC)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start), .tick_o(tick)
  );

  uwire_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_i), .op_i(op_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .eng_done_i(eng_done), .eng_tmo_i(eng_tmo), .eng_rdata_i(eng_rdata),
    .start_o(start), .kind_o(kind), .frame_o(frame), .len_o(len), .rx_o(rx),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o)
  );

  uwire_engine #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .POLL_MAX(POLL_MAX)) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .start_i(start),
    .kind_i(kind), .frame_i(frame), .len_i(len), .rx_i(rx), .do_i(do_i),
    .done_o(eng_done), .timeout_o(eng_tmo), .rdata_o(eng_rdata),
    .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o)
  );

  a_r1_idle_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cs_o);
  a_r3_clock_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o);
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/uwire_eeprom_ctrl_bench.sv
`timescale 1ns/1ps
module uwire_eeprom_ctrl_bench;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [7:0]  addr = 8'd0;
  logic [15:0] wdata = 16'd0;
  logic        busy, done, err, cs, sk, di, dout;
  logic [15:0] rdata;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  uwire_eeprom_ctrl u_uwire_eeprom_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .cs_o(cs), .sk_o(sk), .di_o(di), .do_i(dout)
  );

  // scoreboard of expected frames
  int          q_len[$];
  logic [26:0] q_val[$];
  string       q_tag[$];

  // device model state
  int          nbits = 0;
  logic [26:0] fval = '0;
  bit          in_read = 0;
  logic        rbit = 1'b0;
  logic        rdy = 1'b0;
  logic [15:0] rd_word = '0;
  int          ready_lat = 10;
  int          wcnt = 0;
  bit          mon_on = 0;
  int          extra = 0;
  time         t_rise = 0, sk_width = 0, t_fall = 0, min_gap = 0;
  bit          have_fall = 0;

  assign dout = in_read ? rbit : rdy;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push(input int l, input logic [26:0] v, input string t);
    q_len.push_back(l); q_val.push_back(v); q_tag.push_back(t);
  endtask

  always @(posedge cs) begin
    if (mon_on && have_fall && (min_gap == 0 || $time - t_fall < min_gap))
      min_gap = $time - t_fall;
    nbits = 0; fval = '0; in_read = 0; rbit = 1'b0;
  end

  always @(posedge sk) if (cs) begin
    t_rise = $time;
    fval = {fval[25:0], di};
    nbits++;
    if (nbits == 11 && fval[10:8] == 3'b110) in_read = 1;
    if (in_read && nbits > 11) rbit = rd_word[27-nbits];
  end

  always @(negedge sk) sk_width = $time - t_rise;

  // monitor: pops expected frame at each deselect
  always @(negedge cs) if (mon_on) begin
    t_fall = $time; have_fall = 1;
    if (q_len.size() == 0) begin
      extra++;
      chk(0, "R10", "unexpected frame", fval, 0);
    end else begin
      int el; logic [26:0] ev; string et;
      el = q_len.pop_front(); ev = q_val.pop_front(); et = q_tag.pop_front();
      chk(nbits == el, et, "frame length", nbits, el);
      chk(fval == ev, et, "frame bits", fval, ev);
    end
  end

  // ready indication during waits
  always @(negedge clk) begin
    if (!cs || nbits != 0) begin rdy = 1'b0; wcnt = 0; end
    else if (ready_lat >= 0) begin
      wcnt++;
      if (wcnt > ready_lat) rdy = 1'b1;
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [7:0] a, input logic [15:0] d,
                        input bit exp_err, input bit poke, input string rq);
    int n;
    case (o)
      2'd0: push(27, {3'b110, a, 16'h0}, "R4");
      2'd1: begin
        push(11, 27'h0FF | 27'(3'b100) << 8, "R5");
        push(11, 27'({3'b111, a}), "R6");
        push(0, '0, "R8");
        if (!exp_err) begin
          push(27, {3'b101, a, d}, "R6");
          push(0, '0, "R8");
        end
        push(11, 27'(11'b100_0000_0000), "R9");
      end
      2'd2: push(11, 27'(11'b100_1111_1111), "R5");
      default: push(11, 27'(11'b100_0000_0000), "R5");
    endcase
    @(negedge clk); req = 1'b1; op = o; addr = a; wdata = d;
    @(negedge clk); req = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      req = 1'b1; op = 2'd3; addr = 8'h3C;
      @(negedge clk); req = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done == 1'b1, rq, "done seen", done, 1);
    chk(err == exp_err, "R9", "error flag", err, exp_err);
    if (o == 2'd0) chk(rdata == rd_word, "R4", "read word", rdata, rd_word);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10", "done one cycle", done, 0);
    chk(q_len.size() == 0, rq, "frames pending", q_len.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10", "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err, cs, sk} == 5'b0, "R1", "reset state", {busy, done, err, cs, sk}, 0);
    mon_on = 1;

    run_op(2'd2, 8'h00, 16'h0, 0, 0, "R5");
    chk(sk_width == P * 10, "R3", "clock high width", sk_width, P * 10);
    run_op(2'd3, 8'h00, 16'h0, 0, 0, "R5");
    rd_word = 16'hA5C3;
    run_op(2'd0, 8'h00, 16'h0, 0, 0, "R4");
    rd_word = 16'h0001;
    run_op(2'd0, 8'hFF, 16'h0, 0, 0, "R2");
    run_op(2'd1, 8'h5A, 16'h8001, 0, 0, "R6");
    rd_word = 16'h7FFE;
    run_op(2'd0, 8'h81, 16'h0, 0, 1, "R10");
    repeat (300) @(negedge clk);
    chk(extra == 0 && !busy && !cs, "R10", "busy request ignored", extra, 0);
    ready_lat = -1;
    run_op(2'd1, 8'h12, 16'h3456, 1, 0, "R9");
    ready_lat = 10;
    chk(min_gap >= 3 * P * 10, "R7", "deselect gap", min_gap, 3 * P * 10);
    rd_word = 16'hFFFF;
    run_op(2'd0, 8'h33, 16'h0, 0, 0, "R9");
    chk(err == 1'b0, "R9", "error cleared", err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule